// File: doc/BRIEF.md
# Packed Multiply-Accumulate, SAD and Average Datapath

This block is one SIMD arithmetic stage for a media coprocessor. It takes two packed operands, each four halfword lanes or eight byte lanes wide. A 4-bit operation code selects one of several lane-wise arithmetic functions. The result word and a packed zero-flag word are registered once. They appear on the clock edge after the operands are presented. There is no valid handshake. The register captures whatever the inputs hold on every edge.

The operation groups are:
- Halfword products folded pairwise into two half-width sums.
- A four-lane multiply-accumulate that reduces to a single wide value.
- Per-lane halfword products that keep either the low or the high half of the product.
- Sums of absolute differences over bytes or halfwords.
- Byte or halfword averages with an optional rounding bit.

Only the averages report per-lane zero flags. Any other code leaves the flag word at zero. The four unassigned codes pass the first operand through. No result saturates.

The halfword width `HALF_W` is a parameter. The operand width is `4*HALF_W` and a byte lane is `HALF_W/2` wide. The flag word is always 32 bits, and its bit positions are fixed by lane index.

Top module: `simd_mac_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `flags_o` read zero, whatever the other inputs are.
- R2: Codes 0 (signed) and 1 (unsigned) take the halfword products of lanes 0 and 1, sum them, and truncate the sum into the low half of the result. Lanes 2 and 3 go the same way into the high half.
- R3: Code 2 returns the sum of the absolute differences of all eight byte lanes. The sum is zero-extended to the full result width and never exceeds 8*(2^byte_width-1).
- R4: Code 3 returns the sum of the absolute differences of the four halfword lanes, zero-extended to the full result width.
- R5: Codes 4 and 5 form a signed product in each halfword lane; codes 6 and 7 form an unsigned product. An even code keeps product bits [HALF_W-1:0]. An odd code keeps bits [2*HALF_W-1:HALF_W], which is the product shifted right by HALF_W.
- R6: Code 8 sums the four signed halfword products and sign-extends the sum to the full width. Code 9 sums the four unsigned products and zero-extends the sum.
- R7: Codes 10 (byte lanes) and 11 (halfword lanes) give (a + b + rnd_i) >> 1 in each lane, computed without overflow. A lane is bits [w*i+w-1 : w*i].
- R8: After code 10, bit 4*i+2 of `flags_o` is set exactly when byte lane i of the result is zero. After code 11, bit 8*i+6 is set exactly when halfword lane i is zero. All other flag bits are zero.
- R9: For codes 0 to 9, `flags_o` is zero, and `rnd_i` has no effect on the result.
- R10: Codes 12 to 15 return `opnd_a_i` unchanged and clear `flags_o`.
- R11: The result and flags of the inputs present at one rising edge appear right after that edge. A new operation can be issued every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| rnd_i | input | 1 | Rounding bit for averages |
| opnd_a_i | input | 4*HALF_W | First packed operand |
| opnd_b_i | input | 4*HALF_W | Second packed operand |
| result_o | output | 4*HALF_W | Registered packed result |
| flags_o | output | 32 | Registered packed zero flags |

## Verification
The bench builds the unit with `HALF_W=4`. This gives 16-bit operands, 2-bit byte lanes and 4-bit halfword lanes. With lanes this narrow, every value pair of lane 0 is swept exhaustively under every code, while the other lanes carry pseudo-random data.

The narrow lanes also make the arithmetic edge cases frequent:
- the most negative signed halfword,
- all-ones unsigned products,
- all-zero average lanes with rounding off, which set every flag,
- the largest byte SAD.

Every code, including the four unassigned ones, is issued back to back. This also checks the single-cycle latency.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

  // Operation codes
  localparam logic [3:0] OP_MADD_S = 4'd0;
  localparam logic [3:0] OP_MADD_U = 4'd1;
  localparam logic [3:0] OP_SAD_B  = 4'd2;
  localparam logic [3:0] OP_SAD_H  = 4'd3;
  localparam logic [3:0] OP_MUL_SL = 4'd4;
  localparam logic [3:0] OP_MUL_SH = 4'd5;
  localparam logic [3:0] OP_MUL_UL = 4'd6;
  localparam logic [3:0] OP_MUL_UH = 4'd7;
  localparam logic [3:0] OP_MAC_S  = 4'd8;
  localparam logic [3:0] OP_MAC_U  = 4'd9;
  localparam logic [3:0] OP_AVG_B  = 4'd10;
  localparam logic [3:0] OP_AVG_H  = 4'd11;
  localparam logic [3:0] OP_LAST   = 4'd11;

  // Lane layout of one packed word
  localparam int BYTE_LANES = 8;
  localparam int HALF_LANES = 4;

  // Zero-flag word: a byte lane owns bit 4*i+2, a halfword lane owns bit 8*i+6
  localparam int          FLAG_W          = 32;
  localparam int          BYTE_FLAG_PITCH = 4;
  localparam int          BYTE_FLAG_OFS   = 2;
  localparam int          HALF_FLAG_PITCH = 8;
  localparam int          HALF_FLAG_OFS   = 6;
  localparam logic [31:0] BYTE_FLAG_MASK  = 32'h4444_4444;
  localparam logic [31:0] HALF_FLAG_MASK  = 32'h4040_4040;

endpackage

// File: rtl/simd_prod_unit.sv
module simd_prod_unit
  import simd_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [4*HALF_W-1:0] a_i,
  input  logic [4*HALF_W-1:0] b_i,
  input  logic                is_signed_i,
  input  logic                take_hi_i,
  output logic [4*HALF_W-1:0] madd_o,
  output logic [4*HALF_W-1:0] mul_o,
  output logic [4*HALF_W-1:0] mac_o
);

  localparam int DW = 4 * HALF_W;
  localparam int PW = 2 * HALF_W;   // full product width
  localparam int AW = PW + 2;       // accumulator width for four products

  // One halfword product; the operands are widened first, so the truncated
  // product is exact in both signed and unsigned form.
  function automatic logic [PW-1:0] lane_product(
    input logic [HALF_W-1:0] x,
    input logic [HALF_W-1:0] y,
    input logic              sgn
  );
    logic [PW-1:0] xe;
    logic [PW-1:0] ye;
    xe = sgn ? {{HALF_W{x[HALF_W-1]}}, x} : {{HALF_W{1'b0}}, x};
    ye = sgn ? {{HALF_W{y[HALF_W-1]}}, y} : {{HALF_W{1'b0}}, y};
    return xe * ye;
  endfunction

  // Extends a product to accumulator width, with sign or with zeros.
  function automatic logic [AW-1:0] widen(
    input logic [PW-1:0] p,
    input logic          sgn
  );
    return sgn ? {{2{p[PW-1]}}, p} : {2'b00, p};
  endfunction

  logic [PW-1:0] lane_prod [HALF_LANES];

  for (genvar l = 0; l < HALF_LANES; l++) begin : g_lane
    assign lane_prod[l] = lane_product(a_i[l*HALF_W +: HALF_W],
                                       b_i[l*HALF_W +: HALF_W], is_signed_i);
    // Per-lane product: keep the low half or the product shifted by HALF_W
    assign mul_o[l*HALF_W +: HALF_W] = take_hi_i ? lane_prod[l][PW-1:HALF_W]
                                                 : lane_prod[l][HALF_W-1:0];
  end

  // Pairwise multiply-add, each pair sum truncated to its half of the word
  logic [PW-1:0] pair_lo;
  logic [PW-1:0] pair_hi;
  assign pair_lo = lane_prod[0] + lane_prod[1];
  assign pair_hi = lane_prod[2] + lane_prod[3];
  assign madd_o  = {pair_hi, pair_lo};

  // Four-lane multiply-accumulate, exact in AW bits, then extended
  logic [AW-1:0] mac_sum;
  always_comb begin
    mac_sum = '0;
    for (int l = 0; l < HALF_LANES; l++) begin
      mac_sum = mac_sum + widen(lane_prod[l], is_signed_i);
    end
  end

  assign mac_o = is_signed_i ? {{(DW-AW){mac_sum[AW-1]}}, mac_sum}
                             : {{(DW-AW){1'b0}}, mac_sum};

endmodule

// File: rtl/simd_sad_unit.sv
module simd_sad_unit
  import simd_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [4*HALF_W-1:0] a_i,
  input  logic [4*HALF_W-1:0] b_i,
  input  logic                half_mode_i,
  output logic [4*HALF_W-1:0] sad_o
);

  localparam int DW  = 4 * HALF_W;
  localparam int BW  = HALF_W / 2;
  localparam int SBW = BW + 3;       // eight byte differences
  localparam int SHW = HALF_W + 2;   // four halfword differences

  // Absolute difference formed one bit wider, so it cannot wrap
  function automatic logic [BW-1:0] abs_diff_b(
    input logic [BW-1:0] x,
    input logic [BW-1:0] y
  );
    logic [BW:0] d;
    logic [BW:0] nd;
    d  = {1'b0, x} - {1'b0, y};
    nd = -d;
    return d[BW] ? nd[BW-1:0] : d[BW-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] abs_diff_h(
    input logic [HALF_W-1:0] x,
    input logic [HALF_W-1:0] y
  );
    logic [HALF_W:0] d;
    logic [HALF_W:0] nd;
    d  = {1'b0, x} - {1'b0, y};
    nd = -d;
    return d[HALF_W] ? nd[HALF_W-1:0] : d[HALF_W-1:0];
  endfunction

  logic [BW-1:0]     diff_b [BYTE_LANES];
  logic [HALF_W-1:0] diff_h [HALF_LANES];

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
    assign diff_b[i] = abs_diff_b(a_i[i*BW +: BW], b_i[i*BW +: BW]);
  end

  for (genvar i = 0; i < HALF_LANES; i++) begin : g_half
    assign diff_h[i] = abs_diff_h(a_i[i*HALF_W +: HALF_W], b_i[i*HALF_W +: HALF_W]);
  end

  logic [SBW-1:0] sum_b;
  logic [SHW-1:0] sum_h;

  always_comb begin
    sum_b = '0;
    for (int i = 0; i < BYTE_LANES; i++) begin
      sum_b = sum_b + {{(SBW-BW){1'b0}}, diff_b[i]};
    end
    sum_h = '0;
    for (int i = 0; i < HALF_LANES; i++) begin
      sum_h = sum_h + {{(SHW-HALF_W){1'b0}}, diff_h[i]};
    end
  end

  assign sad_o = half_mode_i ? {{(DW-SHW){1'b0}}, sum_h}
                             : {{(DW-SBW){1'b0}}, sum_b};

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
  import simd_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [4*HALF_W-1:0] a_i,
  input  logic [4*HALF_W-1:0] b_i,
  input  logic                half_mode_i,
  input  logic                rnd_i,
  output logic [4*HALF_W-1:0] avg_o,
  output logic [FLAG_W-1:0]   flags_o
);

  localparam int DW = 4 * HALF_W;
  localparam int BW = HALF_W / 2;

  // (x + y + r) >> 1, with the sum kept one bit wider than the lane
  function automatic logic [BW-1:0] avg_b(
    input logic [BW-1:0] x,
    input logic [BW-1:0] y,
    input logic          r
  );
    logic [BW:0] s;
    s = {1'b0, x} + {1'b0, y} + {{BW{1'b0}}, r};
    return s[BW:1];
  endfunction

  function automatic logic [HALF_W-1:0] avg_h(
    input logic [HALF_W-1:0] x,
    input logic [HALF_W-1:0] y,
    input logic              r
  );
    logic [HALF_W:0] s;
    s = {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, r};
    return s[HALF_W:1];
  endfunction

  logic [DW-1:0] byte_vec;
  logic [DW-1:0] half_vec;
  logic [FLAG_W-1:0] byte_zero;
  logic [FLAG_W-1:0] half_zero;

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
    assign byte_vec[i*BW +: BW] = avg_b(a_i[i*BW +: BW], b_i[i*BW +: BW], rnd_i);
  end

  for (genvar i = 0; i < HALF_LANES; i++) begin : g_half
    assign half_vec[i*HALF_W +: HALF_W] =
      avg_h(a_i[i*HALF_W +: HALF_W], b_i[i*HALF_W +: HALF_W], rnd_i);
  end

  // Zero flags placed at their fixed slots in the flag word
  always_comb begin
    byte_zero = '0;
    half_zero = '0;
    for (int i = 0; i < BYTE_LANES; i++) begin
      byte_zero[i*BYTE_FLAG_PITCH + BYTE_FLAG_OFS] = ~|byte_vec[i*BW +: BW];
    end
    for (int i = 0; i < HALF_LANES; i++) begin
      half_zero[i*HALF_FLAG_PITCH + HALF_FLAG_OFS] = ~|half_vec[i*HALF_W +: HALF_W];
    end
  end

  assign avg_o   = half_mode_i ? half_vec  : byte_vec;
  assign flags_o = half_mode_i ? half_zero : byte_zero;

endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          op_i,
  input  logic                rnd_i,
  input  logic [4*HALF_W-1:0] opnd_a_i,
  input  logic [4*HALF_W-1:0] opnd_b_i,
  output logic [4*HALF_W-1:0] result_o,
  output logic [31:0]         flags_o
);

  localparam int DW = 4 * HALF_W;
  localparam int BW = HALF_W / 2;
  localparam int AW = 2 * HALF_W + 2;
  localparam logic [DW-1:0] SAD_B_MAX = DW'(BYTE_LANES * ((1 << BW) - 1));

  // Decoded controls, named for the assertions
  logic is_signed;
  logic take_hi;
  logic sad_half;
  logic avg_half;
  logic is_avg;
  logic is_defined;

  assign is_signed  = (op_i == OP_MADD_S) || (op_i == OP_MUL_SL) ||
                      (op_i == OP_MUL_SH) || (op_i == OP_MAC_S);
  assign take_hi    = (op_i == OP_MUL_SH) || (op_i == OP_MUL_UH);
  assign sad_half   = (op_i == OP_SAD_H);
  assign avg_half   = (op_i == OP_AVG_H);
  assign is_avg     = (op_i == OP_AVG_B) || (op_i == OP_AVG_H);
  assign is_defined = (op_i <= OP_LAST);

  logic [DW-1:0]     madd_res;
  logic [DW-1:0]     mul_res;
  logic [DW-1:0]     mac_res;
  logic [DW-1:0]     sad_res;
  logic [DW-1:0]     avg_res;
  logic [FLAG_W-1:0] avg_flags;

  simd_prod_unit #(.HALF_W(HALF_W)) u_prod (
    .a_i         (opnd_a_i),
    .b_i         (opnd_b_i),
    .is_signed_i (is_signed),
    .take_hi_i   (take_hi),
    .madd_o      (madd_res),
    .mul_o       (mul_res),
    .mac_o       (mac_res)
  );

  simd_sad_unit #(.HALF_W(HALF_W)) u_sad (
    .a_i         (opnd_a_i),
    .b_i         (opnd_b_i),
    .half_mode_i (sad_half),
    .sad_o       (sad_res)
  );

  simd_avg_unit #(.HALF_W(HALF_W)) u_avg (
    .a_i         (opnd_a_i),
    .b_i         (opnd_b_i),
    .half_mode_i (avg_half),
    .rnd_i       (rnd_i),
    .avg_o       (avg_res),
    .flags_o     (avg_flags)
  );

  logic [DW-1:0]     result_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    case (op_i)
      OP_MADD_S, OP_MADD_U:                        result_d = madd_res;
      OP_SAD_B, OP_SAD_H:                          result_d = sad_res;
      OP_MUL_SL, OP_MUL_SH, OP_MUL_UL, OP_MUL_UH:  result_d = mul_res;
      OP_MAC_S, OP_MAC_U:                          result_d = mac_res;
      OP_AVG_B, OP_AVG_H:                          result_d = avg_res;
      default:                                     result_d = opnd_a_i;
    endcase
    flags_d = (is_avg && is_defined) ? avg_flags : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= result_d;
      flags_o  <= flags_d;
    end
  end

  // Unassigned codes: operand A passes through and the flags are clear
  assert_undef_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_LAST) |=> (result_o == $past(opnd_a_i)) && (flags_o == '0));

  // Flags stay clear after every non-average code
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= OP_MAC_U) |=> (flags_o == '0));

  // Byte averages write only the byte flag slots
  assert_byte_flag_slots_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AVG_B) |=> ((flags_o & ~BYTE_FLAG_MASK) == '0));

  // Halfword averages write only the halfword flag slots
  assert_half_flag_slots_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AVG_H) |=> ((flags_o & ~HALF_FLAG_MASK) == '0));

  // Byte SAD cannot exceed eight full-scale differences
  assert_sad_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SAD_B) |=> (result_o <= SAD_B_MAX));

  // Signed MAC: all bits above the exact sum copy its sign
  assert_mac_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MAC_S) |=> (($countones(result_o[DW-1:AW-1]) == 0) ||
                            ($countones(result_o[DW-1:AW-1]) == DW-AW+1)));

endmodule

// File: tb/sim_simd_mac_unit.sv
module sim_simd_mac_unit;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 4;
  localparam int DW = 4 * HW;
  localparam int VECS = 3000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_i = '0;
  logic          rnd_i = 1'b0;
  logic [DW-1:0] opnd_a_i = '0;
  logic [DW-1:0] opnd_b_i = '0;
  logic [DW-1:0] result_o;
  logic [31:0]   flags_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mac_unit #(.HALF_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rnd_i(rnd_i),
    .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  function automatic int fld(input logic [DW-1:0] v, input int idx, input int w);
    int vv;
    vv = int'(v);
    return (vv >> (idx * w)) & ((1 << w) - 1);
  endfunction

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:             return "R2 R9";
      4'd2:                   return "R3 R9";
      4'd3:                   return "R4 R9";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5 R9";
      4'd8, 4'd9:             return "R6 R9";
      4'd10, 4'd11:           return "R7 R8";
      default:                return "R10";
    endcase
  endfunction

  // Arithmetic restatement of the requirements, using integers
  task automatic model(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic r, output logic [DW-1:0] res, output logic [31:0] flg);
    int acc, x, y, p, v, w, n;
    res = '0;
    flg = '0;
    acc = 0;
    case (op)
      4'd0, 4'd1: begin
        for (int k = 0; k < 2; k++) begin
          acc = 0;
          for (int j = 0; j < 2; j++) begin
            x = fld(a, 2*k + j, HW);
            y = fld(b, 2*k + j, HW);
            if (op == 4'd0) begin x = sx(x, HW); y = sx(y, HW); end
            acc += x * y;
          end
          res = res | DW'((acc & ((1 << (2*HW)) - 1)) << (2*HW*k));
        end
      end
      4'd2, 4'd3: begin
        w = (op == 4'd2) ? HW/2 : HW;
        n = (op == 4'd2) ? 8 : 4;
        for (int l = 0; l < n; l++) begin
          x = fld(a, l, w);
          y = fld(b, l, w);
          acc += (x > y) ? x - y : y - x;
        end
        res = DW'(acc);
      end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        for (int l = 0; l < 4; l++) begin
          x = fld(a, l, HW);
          y = fld(b, l, HW);
          if (op < 4'd6) begin x = sx(x, HW); y = sx(y, HW); end
          p = x * y;
          v = op[0] ? (p >>> HW) : p;
          res = res | DW'((v & ((1 << HW) - 1)) << (HW*l));
        end
      end
      4'd8, 4'd9: begin
        for (int l = 0; l < 4; l++) begin
          x = fld(a, l, HW);
          y = fld(b, l, HW);
          if (op == 4'd8) begin x = sx(x, HW); y = sx(y, HW); end
          acc += x * y;
        end
        res = DW'(acc);
      end
      4'd10, 4'd11: begin
        w = (op == 4'd10) ? HW/2 : HW;
        n = (op == 4'd10) ? 8 : 4;
        for (int l = 0; l < n; l++) begin
          v = (fld(a, l, w) + fld(b, l, w) + int'(r)) >> 1;
          res = res | DW'(v << (l*w));
          if (v == 0) flg[(op == 4'd10) ? 4*l + 2 : 8*l + 6] = 1'b1;
        end
      end
      default: res = a;
    endcase
  endtask

  logic          pend = 1'b0;
  logic [3:0]    pend_op;
  logic [DW-1:0] pend_a, pend_b;
  logic          pend_r;
  logic [DW-1:0] exp_res;
  logic [31:0]   exp_flg;

  // Result of the vector issued one edge earlier (R11 single-cycle latency)
  task automatic compare_pending();
    if (pend) begin
      checks++;
      if (result_o !== exp_res || flags_o !== exp_flg) begin
        errors++;
        $display("FAIL %s op=%0d a=%h b=%h r=%0d result=%h expected=%h flags=%h expected=%h",
                 req_of(pend_op), pend_op, pend_a, pend_b, pend_r,
                 result_o, exp_res, flags_o, exp_flg);
      end
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic r);
    @(negedge clk);
    compare_pending();
    op_i = op; opnd_a_i = a; opnd_b_i = b; rnd_i = r;
    model(op, a, b, r, exp_res, exp_flg);
    pend_op = op; pend_a = a; pend_b = b; pend_r = r; pend = 1'b1;
  endtask

  logic [31:0] rng = 32'h1bad_5eed;

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  initial begin
    logic [DW-1:0] a, b;
    logic r;
    // R1: reset holds outputs at zero even with live inputs
    op_i = 4'd12; opnd_a_i = '1; opnd_b_i = '1; rnd_i = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== '0 || flags_o !== '0) begin
      errors++;
      $display("FAIL R1 result=%h expected=0 flags=%h expected=0", result_o, flags_o);
    end
    op_i = 4'd0; opnd_a_i = '0; opnd_b_i = '0; rnd_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < VECS; i++) begin
        step_rng(); a = rng[15:0]; b = rng[31:16];
        step_rng(); r = rng[9];
        if (i < 256) begin
          // Exhaustive sweep of lane 0 values
          a[3:0] = i[3:0];
          b[3:0] = i[7:4];
        end
        case (i)
          256: begin a = '1; b = '1; end                   // all-ones lanes
          257: begin a = 16'h8888; b = 16'h8888; end       // most negative halfwords
          258: begin a = '1; b = '0; end                   // largest differences
          259: begin a = '0; b = '0; r = 1'b0; end         // zero averages, all flags
          260: begin a = '0; b = '0; r = 1'b1; end         // rounding on zeros
          default: ;
        endcase
        apply(4'(op), a, b, r);
      end
    end
    @(negedge clk);
    compare_pending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule